// File: doc/BRIEF.md
# Asynchronous static memory timing sequencer

This block drives the strobes of one external asynchronous static memory bank: an active-low chip select, an active-low output enable, an active-low write enable, a word address and write data. Every interval is counted in memory clocks. A 3-bit device code selects one of four protocols: plain ROM or flash, SRAM, ROM or flash with groups of four fast beats, or ROM or flash with groups of eight fast beats. Two programmable delays set the timing. The long delay applies to the first access of a group. The short delay applies to each later access that stays inside the same aligned group.

A requester holds `req_valid` together with a word address, a read/write flag, a beat count and write data until it sees `req_ack`. A read returns one data word per beat on `rd_data`, marked by a one-clock `rd_valid`. A write always performs a single access, whatever the device type and whatever the beat count.

Top module: `static_mem_seq`

## Requirements
- R1: After reset, `mem_ncs`, `mem_noe` and `mem_nwe` are high, and `req_ack` and `rd_valid` are low. While no request is in progress the block holds these values.
- R2: Device codes are 000 plain, 001 SRAM, 010 four-beat groups and 011 eight-beat groups. A request made under code 100, 101, 110 or 111 drives no strobe and no chip select, and is acknowledged in the clock after it is accepted.
- R3: `mem_ncs` falls one clock before the first strobe falls. It rises one clock after the last strobe rises. `req_ack` is high for exactly that one clock.
- R4: A read of `req_len`+1 beats (`req_len` holds the beat count minus one) presents word address start+i on beat i, wrapping modulo 2^AW. `mem_noe` stays low without a gap from the first beat to the last.
- R5: The first beat of a read lasts `cfg_first_dly`+1 clocks. On plain and SRAM devices every beat lasts `cfg_first_dly`+1 clocks.
- R6: On grouped devices, a later beat whose address is not at a group start lasts `cfg_next_dly`+1 clocks. A group spans the low 2 word-address bits for code 010 and the low 3 bits for code 011.
- R7: A later beat on a grouped device whose address has all group bits zero starts a new group and lasts `cfg_first_dly`+1 clocks.
- R8: `mem_din` is sampled on the last clock of each read beat. It appears on `rd_data` with `rd_valid` high for one clock, in the clock after that beat.
- R9: A write request performs exactly one write access, whatever the device code and the beat count.
- R10: On SRAM, `mem_nwe` is low for `cfg_next_dly`+1 clocks and then high for one clock. `mem_addr` and `mem_dout` are held over all `cfg_next_dly`+2 clocks.
- R11: On code 000, 010 or 011, a write keeps `mem_nwe` low for `cfg_first_dly`+1 clocks, followed by the same one-clock recovery.
- R12: A request is taken only while the block is idle and `req_ack` is low. The address, flag, count, write data and configuration are latched when the request is taken, so later changes to these inputs have no effect until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_type | input | 3 | Device code |
| cfg_first_dly | input | DLYW | Long (group start) delay |
| cfg_next_dly | input | DLYW | Short (in-group and write) delay |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start word address |
| req_len | input | LENW | Read beats minus one |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | Read data strobe |
| mem_ncs | output | 1 | Chip select, active low |
| mem_noe | output | 1 | Output enable, active low |
| mem_nwe | output | 1 | Write enable, active low |
| mem_addr | output | AW | Word address to the memory |
| mem_dout | output | DW | Write data to the memory |
| mem_din | input | DW | Read data from the memory |

## Verification
A request is taken at the clock edge that follows its presentation. Chip select falls in the next clock, and the first strobe falls one clock after that. Each beat then runs for its delay plus one clock. Read data follows one clock after the end of its beat, and the acknowledge comes one clock after the last strobe rises. An unsupported code is acknowledged in the clock right after acceptance. From every request the bench builds the expected level of each output for each of these clocks and compares them all at the falling edge. When nothing is queued it expects the idle levels, so any extra or early activity is caught.

// File: rtl/asmseq_pkg.sv
// Shared device codes, sequencer states and helper functions for the
// static memory sequencer. Assumes a 3-bit device code.
package asmseq_pkg;

    localparam logic [2:0] DEV_PLAIN  = 3'b000;
    localparam logic [2:0] DEV_SRAM   = 3'b001;
    localparam logic [2:0] DEV_GRP4   = 3'b010;
    localparam logic [2:0] DEV_GRP8   = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_READ,
        ST_WRITE,
        ST_TAIL
    } seq_state_e;

    // True for the four codes the sequencer knows how to drive.
    function automatic logic dev_supported(input logic [2:0] code);
        return code <= DEV_GRP8;
    endfunction

    // True for the codes whose reads may use short in-group beats.
    function automatic logic dev_grouped(input logic [2:0] code);
        return (code == DEV_GRP4) || (code == DEV_GRP8);
    endfunction

    // Mask of word-address bits that may change inside one group.
    function automatic logic [2:0] dev_group_mask(input logic [2:0] code);
        return (code == DEV_GRP8) ? 3'b111 : 3'b011;
    endfunction

endpackage

// File: rtl/asmseq_timer.sv
// Beat timer: a down counter that is loaded with a delay value and
// reports expiry when it reaches zero. A loaded value D gives a beat
// of D+1 clocks. Assumes load has priority over counting.
module asmseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load a new delay or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asmseq_addr.sv
// Word-address register for the memory bus. It loads a start address,
// steps by one per beat, and flags when the next address starts a new
// aligned group under the given mask. Assumes AW >= 3.
module asmseq_addr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [2:0]    grp_mask,
    output logic [AW-1:0] addr,
    output logic          next_at_start
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_inc;

    // Next sequential word address and group-start detection.
    always_comb begin
        addr_inc      = addr_q + 1'b1;
        next_at_start = ((addr_inc[2:0] & grp_mask) == 3'b000);
    end

    // Hold, load or advance the bus address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= addr_inc;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/asmseq_capture.sv
// Read-data capture: samples the memory data bus when told to and
// presents it with a one-clock valid strobe in the following clock.
module asmseq_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] data,
    output logic          valid
);

    // Register the sampled word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= cap;
            if (cap) begin
                data <= din;
            end
        end
    end

endmodule

// File: rtl/static_mem_seq.sv
// Asynchronous static memory timing sequencer for one bank.
// It accepts a request, asserts chip select for one lead clock, runs
// read beats or a single write beat, and then gives one tail clock
// before it releases chip select and acknowledges. Assumptions: the
// requester holds req_valid until it sees req_ack, and the memory
// drives mem_din in time for the last clock of each read beat.
module static_mem_seq
    import asmseq_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 32,
    parameter int DLYW = 4,
    parameter int LENW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cfg_type,
    input  logic [DLYW-1:0] cfg_first_dly,
    input  logic [DLYW-1:0] cfg_next_dly,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ack,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            mem_ncs,
    output logic            mem_noe,
    output logic            mem_nwe,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_dout,
    input  logic [DW-1:0]   mem_din
);

    localparam logic [LENW-1:0] LEN_ZERO = '0;

    seq_state_e      state_q;
    logic            ncs_q, noe_q, nwe_q, ack_q, wr_q;
    logic [2:0]      typ_q;
    logic [DLYW-1:0] first_q, next_q;
    logic [AW-1:0]   start_q;
    logic [DW-1:0]   wdata_q;
    logic [LENW-1:0] left_q;

    logic            tmr_load, tmr_expired;
    logic [DLYW-1:0] tmr_val;
    logic            ag_load, ag_step, ag_next_start;
    logic [2:0]      grp_mask;
    logic            cap;
    logic            take_req;

    assign grp_mask = dev_group_mask(typ_q);
    assign take_req = (state_q == ST_IDLE) && req_valid && !ack_q;

    // Beat timer shared by read and write beats.
    asmseq_timer #(.W(DLYW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Bus address register with group-start detection.
    asmseq_addr #(.AW(AW)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (ag_load),
        .load_val      (start_q),
        .step          (ag_step),
        .grp_mask      (grp_mask),
        .addr          (mem_addr),
        .next_at_start (ag_next_start)
    );

    // Read data capture at the end of each beat.
    asmseq_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (mem_din),
        .data  (rd_data),
        .valid (rd_valid)
    );

    // Per-state timer loads, address moves and capture strobes.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = first_q;
        ag_load  = 1'b0;
        ag_step  = 1'b0;
        cap      = 1'b0;
        case (state_q)
            ST_LEAD: begin
                tmr_load = 1'b1;
                ag_load  = 1'b1;
                if (wr_q && (typ_q == DEV_SRAM)) begin
                    tmr_val = next_q;
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    cap = 1'b1;
                    if (left_q != LEN_ZERO) begin
                        ag_step  = 1'b1;
                        tmr_load = 1'b1;
                        if (dev_grouped(typ_q) && !ag_next_start) begin
                            tmr_val = next_q;
                        end
                    end
                end
            end
            default: begin
            end
        endcase
    end

    // Sequencer state, strobes, acknowledge and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ncs_q   <= 1'b1;
            noe_q   <= 1'b1;
            nwe_q   <= 1'b1;
            ack_q   <= 1'b0;
            wr_q    <= 1'b0;
            typ_q   <= DEV_PLAIN;
            first_q <= '0;
            next_q  <= '0;
            start_q <= '0;
            wdata_q <= '0;
            left_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_req) begin
                        if (dev_supported(cfg_type)) begin
                            ncs_q   <= 1'b0;
                            state_q <= ST_LEAD;
                            wr_q    <= req_write;
                            typ_q   <= cfg_type;
                            first_q <= cfg_first_dly;
                            next_q  <= cfg_next_dly;
                            start_q <= req_addr;
                            wdata_q <= req_wdata;
                            left_q  <= req_write ? LEN_ZERO : req_len;
                        end else begin
                            ack_q <= 1'b1;
                        end
                    end
                end
                ST_LEAD: begin
                    if (wr_q) begin
                        nwe_q   <= 1'b0;
                        state_q <= ST_WRITE;
                    end else begin
                        noe_q   <= 1'b0;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (tmr_expired) begin
                        if (left_q == LEN_ZERO) begin
                            noe_q   <= 1'b1;
                            state_q <= ST_TAIL;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (tmr_expired) begin
                        nwe_q   <= 1'b1;
                        state_q <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    ncs_q   <= 1'b1;
                    ack_q   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_ncs  = ncs_q;
    assign mem_noe  = noe_q;
    assign mem_nwe  = nwe_q;
    assign mem_dout = wdata_q;
    assign req_ack  = ack_q;

    // R2: an unsupported code never opens the bank, and it is acknowledged.
    a_r2_unsupported_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !dev_supported(cfg_type)) |=> (mem_ncs && req_ack));

    // R3: strobes only inside chip select.
    a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_noe || !mem_nwe) |-> !mem_ncs);

    // R3: one lead clock before the first strobe.
    a_r3_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ncs) |=> (!mem_noe || !mem_nwe));

    // R3: one tail clock after the last strobe.
    a_r3_cs_tail: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_noe) || $rose(mem_nwe)) |=> $rose(mem_ncs));

    // R3: the acknowledge comes with the chip select release and lasts one clock.
    a_r3_ack_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ncs) |-> req_ack);
    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R4: output enable and write enable are never low together.
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_noe && !mem_nwe));

    // R4, R8: an address step inside a read returns the previous beat's data.
    a_r4_step_returns_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_noe && $past(!mem_noe) && !$stable(mem_addr)) |-> rd_valid);

    // R10: address and data are held while write enable is low and during recovery.
    a_r10_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_nwe)) |-> ($stable(mem_addr) && $stable(mem_dout)));

endmodule

// File: tb/sim_static_mem_seq.sv
`timescale 1ns/1ps
// Bench: builds a per-clock expectation queue from each request and
// compares every output at each falling clock edge.
module sim_static_mem_seq;

    localparam int AW = 20;
    localparam int DW = 32;
    localparam int DLYW = 4;
    localparam int LENW = 4;
    localparam int WATCHDOG = 100000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cfg_type = 3'b000;
    logic [DLYW-1:0] cfg_first_dly = '0;
    logic [DLYW-1:0] cfg_next_dly = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [LENW-1:0] req_len = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ack;
    logic [DW-1:0]   rd_data;
    logic            rd_valid;
    logic            mem_ncs, mem_noe, mem_nwe;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_dout;
    logic [DW-1:0]   mem_din;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_en = 1'b0;

    typedef struct packed {
        logic          ncs, noe, nwe, ack, rv, ca, cd;
        logic [AW-1:0] addr;
        logic [DW-1:0] rdat;
        logic [DW-1:0] wdat;
    } exp_t;

    exp_t  eq[$];
    string tq[$];

    always #10 clk = ~clk;

    static_mem_seq #(.AW(AW), .DW(DW), .DLYW(DLYW), .LENW(LENW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type),
        .cfg_first_dly(cfg_first_dly), .cfg_next_dly(cfg_next_dly),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .req_ack(req_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_ncs(mem_ncs),
        .mem_noe(mem_noe), .mem_nwe(mem_nwe), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        logic [31:0] x;
        x = {12'h000, a};
        return (x * 32'h0001_0013) ^ 32'h5A3C_1E0F;
    endfunction

    // The memory answers with a word that depends on the address alone.
    assign mem_din = mem_fn(mem_addr);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic push(input logic ncs, noe, nwe, ack, rv, ca, cd,
                        input logic [AW-1:0] a, input logic [DW-1:0] rdat,
                        input logic [DW-1:0] wdat, input string tag);
        exp_t e;
        e.ncs = ncs; e.noe = noe; e.nwe = nwe; e.ack = ack; e.rv = rv;
        e.ca = ca; e.cd = cd; e.addr = a; e.rdat = rdat; e.wdat = wdat;
        eq.push_back(e);
        tq.push_back(tag);
    endtask

    // Expected outputs for each clock after acceptance.
    task automatic build(input logic wr, input logic [2:0] ty, input logic [AW-1:0] a0,
                         input int len, input int f, input int n,
                         input logic [DW-1:0] w, input string tag);
        logic [AW-1:0] a;
        logic [2:0]    m;
        int            d;
        if (ty > 3'b011) begin
            push(1, 1, 1, 1, 0, 0, 0, '0, '0, '0, tag);
            return;
        end
        push(0, 1, 1, 0, 0, 0, 0, '0, '0, '0, tag);
        if (wr) begin
            d = (ty == 3'b001) ? n : f;
            for (int c = 0; c <= d; c++) push(0, 1, 0, 0, 0, 1, 1, a0, '0, w, tag);
            push(0, 1, 1, 0, 0, 1, 1, a0, '0, w, tag);
        end else begin
            m = (ty == 3'b011) ? 3'b111 : 3'b011;
            for (int i = 0; i <= len; i++) begin
                a = a0 + AW'(i);
                if (i == 0) d = f;
                else if ((ty == 3'b010 || ty == 3'b011) && ((a[2:0] & m) != 3'b000)) d = n;
                else d = f;
                for (int c = 0; c <= d; c++)
                    push(0, 0, 1, 0, (c == 0 && i > 0), 1, 0, a, mem_fn(a - 1'b1), '0, tag);
            end
            push(0, 1, 1, 0, 1, 0, 0, '0, mem_fn(a0 + AW'(len)), '0, tag);
        end
        push(1, 1, 1, 1, 0, 0, 0, '0, '0, '0, tag);
    endtask

    // Issue one request, scramble the inputs once it is taken (R12), wait for the acknowledge.
    task automatic run_req(input logic wr, input logic [2:0] ty, input logic [AW-1:0] a,
                           input int len, input int f, input int n,
                           input logic [DW-1:0] w, input string tag);
        @(negedge clk); #1;
        cfg_type = ty; cfg_first_dly = DLYW'(f); cfg_next_dly = DLYW'(n);
        req_write = wr; req_addr = a; req_len = LENW'(len); req_wdata = w;
        req_valid = 1'b1;
        build(wr, ty, a, len, f, n, w, tag);
        do begin
            @(negedge clk); #1;
            req_addr = ~a; req_wdata = ~w; req_len = ~LENW'(len); req_write = ~wr;
            cfg_type = 3'b001; cfg_first_dly = ~DLYW'(f); cfg_next_dly = ~DLYW'(n);
        end while (!req_ack);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Compare every output against the expectation of this clock.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            exp_t  e;
            string t;
            if (eq.size() > 0) begin
                e = eq.pop_front();
                t = tq.pop_front();
            end else begin
                e = '{ncs: 1, noe: 1, nwe: 1, ack: 0, rv: 0, ca: 0, cd: 0,
                      addr: '0, rdat: '0, wdat: '0};
                t = "R1 idle";
            end
            chk(mem_ncs === e.ncs, t, "mem_ncs", 64'(mem_ncs), 64'(e.ncs));
            chk(mem_noe === e.noe, t, "mem_noe", 64'(mem_noe), 64'(e.noe));
            chk(mem_nwe === e.nwe, t, "mem_nwe", 64'(mem_nwe), 64'(e.nwe));
            chk(req_ack === e.ack, t, "req_ack", 64'(req_ack), 64'(e.ack));
            chk(rd_valid === e.rv, t, "rd_valid", 64'(rd_valid), 64'(e.rv));
            if (e.ca) chk(mem_addr === e.addr, t, "mem_addr", 64'(mem_addr), 64'(e.addr));
            if (e.cd) chk(mem_dout === e.wdat, t, "mem_dout", 64'(mem_dout), 64'(e.wdat));
            if (e.rv) chk(rd_data === e.rdat, t, "rd_data", 64'(rd_data), 64'(e.rdat));
        end
    end

    // Watchdog: a hung run counts as a failed check and still ends with the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset levels
        chk(mem_ncs && mem_noe && mem_nwe && !req_ack && !rd_valid, "R1", "reset levels",
            {59'h0, mem_ncs, mem_noe, mem_nwe, req_ack, rd_valid}, 64'h1C);
        mon_en = 1'b1;

        // R5 R4 R8: plain device, three beats, every beat long
        run_req(1'b0, 3'b000, 20'h00010, 2, 3, 1, '0, "R5 R4 R8 plain read");
        // R5 R8: SRAM reads are never shortened
        run_req(1'b0, 3'b001, 20'h00105, 1, 2, 0, '0, "R5 R8 sram read");
        // R6 R7: four-beat groups, start inside a group and cross a boundary
        run_req(1'b0, 3'b010, 20'h00022, 5, 4, 1, '0, "R6 R7 group4 read");
        // R6 R7: eight-beat groups crossing a boundary
        run_req(1'b0, 3'b011, 20'h00043, 9, 3, 0, '0, "R6 R7 group8 read");
        // R5: single beat with zero long delay
        run_req(1'b0, 3'b010, 20'h00003, 0, 0, 2, '0, "R5 single beat zero delay");
        // R4 R7: address wraps at the top of the space
        run_req(1'b0, 3'b010, 20'hFFFFE, 3, 2, 1, '0, "R4 R7 address wrap");
        // R9 R10: SRAM write ignores the beat count, uses the short delay
        run_req(1'b1, 3'b001, 20'h00200, 3, 5, 2, 32'hDEAD_BEEF, "R9 R10 sram write");
        // R9 R11: write on a grouped device is one access with the long delay
        run_req(1'b1, 3'b010, 20'h00301, 7, 2, 1, 32'h1234_5678, "R9 R11 group4 write");
        // R11: plain device write with zero delay
        run_req(1'b1, 3'b000, 20'h00400, 0, 0, 3, 32'h0F0F_0F0F, "R11 plain write");
        // R2: unsupported codes
        run_req(1'b0, 3'b100, 20'h00500, 2, 1, 1, '0, "R2 code 100");
        run_req(1'b1, 3'b101, 20'h00501, 0, 1, 1, 32'h1, "R2 code 101");
        run_req(1'b0, 3'b111, 20'h00502, 1, 1, 1, '0, "R2 code 111");
        // R12 R3: back-to-back requests after scrambled inputs
        run_req(1'b0, 3'b011, 20'h00806, 3, 1, 0, '0, "R12 R3 group8 read");
        run_req(1'b1, 3'b011, 20'h00807, 2, 3, 0, 32'hCAFE_F00D, "R12 R3 group8 write");

        repeat (4) @(negedge clk);
        // The whole expectation queue must have been used up.
        chk(eq.size() == 0, "R3", "expectation queue drained", 64'(eq.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule